// File: doc/BRIEF.md
# MII Management Read/Write Engine

This block runs management transactions to an external PHY over the two-wire management interface. A host programs a PHY address and a PHY register number through a small byte-wide register port. It then either sets a read command bit or writes a 16-bit value to trigger a write. The engine divides the system clock down to produce MDC and shifts a complete management frame onto MDIO. For a read, it releases the line after the register field and samples the PHY's reply.

A read result is returned as a low byte and a high byte. A three-bit status word reports three things: whether an operation is still outstanding, whether a continuous scan is enabled, and whether the data bytes are not yet valid. A new read is launched only when the read command bit goes from clear to set, so the host must clear the bit itself before it can start another read. In scan mode the engine re-reads the selected register back to back, and each frame that completes refreshes the data bytes.

Host register numbers: 0 command (bit 0 read, bit 1 scan), 1 PHY register select (5 bits), 2 write data low byte, 3 write data high byte, 4 PHY address (5 bits).

Top module: `mii_mgmt_engine`

## Requirements
- R1: After reset, status_o, rdata_lo_o and rdata_hi_o are zero, mdio_oe_o is 0 and mdc_o is 0.
- R2: mdc_o has a period of CLK_DIV clock cycles and is high for CLK_DIV/2 of them. mdio_o and mdio_oe_o change only in the cycle in which mdc_o falls.
- R3: A read frame drives, MSB first, 32 ones, start bits 01, opcode 10, the 5-bit PHY address and the 5-bit register number. It then releases mdio_oe_o for the two turnaround bits and 16 data bits. The data bits are sampled on the MDC rising edge, MSB first.
- R4: A write frame drives opcode 01, turnaround 10 and 16 data bits. mdio_oe_o stays asserted for all 64 bits.
- R5: A host write to register 0 with bit 0 set, when bit 0 reads clear, launches exactly one read. Writing bit 0 set again while it is still set launches nothing.
- R6: Status bit 0 (busy) is set from the cycle after a launch until the cycle in which the result appears on rdata_hi_o (bits 15:8) and rdata_lo_o (bits 7:0).
- R7: Status bit 2 (not valid) is set by a read launch or by scan being switched on. It is cleared only when read data is latched.
- R8: While command bit 1 is set, status bit 1 is set and the engine reads the selected register repeatedly. Each completed frame updates the data bytes.
- R9: Writing register 3 launches a PHY write whose data is the byte written to register 3 (as bits 15:8) above the byte last written to register 2 (as bits 7:0).
- R10: When several operations are pending at once, a write starts before a read, and a read starts before a scan frame.
- R11: The PHY address field of every frame is the value last written to register 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register number |
| host_wdata | input | 8 | Host write data |
| status_o | output | 3 | {not valid, scan active, busy} |
| rdata_lo_o | output | 8 | Read result bits 7:0 |
| rdata_hi_o | output | 8 | Read result bits 15:8 |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the engine with CLK_DIV = 4, so one frame takes 256 cycles. At that length dozens of reads and writes fit in a short run, as do back-to-back scan frames and a queue of three operations. A small behavioural PHY in the bench decodes each frame: it checks the opcode, the address fields and who drives the turnaround. It answers reads from a register array that the bench can change during a scan, which exposes stale data and ordering faults.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int FRAME_LEN    = 64;
  localparam int PREAMBLE_LEN = 32;
  localparam int DRIVE_RD_LEN = 46;
  localparam int DATA_FIRST   = 48;
  localparam int FIELD_W      = 5;
  localparam int WORD_W       = 16;

  typedef enum logic [2:0] {
    HREG_CMD = 3'd0,
    HREG_SEL = 3'd1,
    HREG_WLO = 3'd2,
    HREG_WHI = 3'd3,
    HREG_PHY = 3'd4
  } host_reg_e;

  typedef struct packed {
    logic               wr;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic [WORD_W-1:0]  wdata;
  } mgmt_req_t;

  // Whole frame, MSB leaves first.
  function automatic logic [FRAME_LEN-1:0] build_frame(mgmt_req_t r);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [WORD_W-1:0] dat;
    op  = r.wr ? 2'b01 : 2'b10;
    ta  = r.wr ? 2'b10 : 2'b00;
    dat = r.wr ? r.wdata : '0;
    return {{PREAMBLE_LEN{1'b1}}, 2'b01, op, r.phy, r.regn, ta, dat};
  endfunction

  // Whether the engine owns the line for bit index idx.
  function automatic logic drive_bit(logic wr, logic [5:0] idx);
    return wr || (idx < 6'(DRIVE_RD_LEN));
  endfunction
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc_o,
  output logic rise_tick_o,
  output logic fall_tick_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_tick_o = (cnt == CW'(HALF - 1));
  assign fall_tick_o = (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt <= fall_tick_o ? '0 : cnt + 1'b1;
      if (rise_tick_o)      mdc_o <= 1'b1;
      else if (fall_tick_o) mdc_o <= 1'b0;
    end
  end

  p_mdc_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o != $past(mdc_o)) |-> $past(rise_tick_o || fall_tick_o));
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
  import mii_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              req_valid,
  input  mgmt_req_t         req,
  output logic              ack_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              active_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic                 active, is_wr, oe;
  logic [5:0]           bitcnt;
  logic [FRAME_LEN-1:0] shreg;
  logic [WORD_W-1:0]    rdsh;

  assign ack_o     = fall_tick && !active && req_valid;
  assign active_o  = active;
  assign mdio_o    = shreg[FRAME_LEN-1];
  assign mdio_oe_o = oe;
  assign rdata_o   = rdsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      is_wr     <= 1'b0;
      oe        <= 1'b0;
      bitcnt    <= '0;
      shreg     <= '0;
      rdsh      <= '0;
      done_o    <= 1'b0;
      done_rd_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      done_rd_o <= 1'b0;
      if (fall_tick) begin
        if (ack_o) begin
          active <= 1'b1;
          is_wr  <= req.wr;
          shreg  <= build_frame(req);
          bitcnt <= '0;
          oe     <= 1'b1;
        end else if (active) begin
          if (bitcnt == 6'(FRAME_LEN - 1)) begin
            active    <= 1'b0;
            oe        <= 1'b0;
            shreg     <= '0;
            done_o    <= 1'b1;
            done_rd_o <= !is_wr;
          end else begin
            shreg  <= {shreg[FRAME_LEN-2:0], 1'b0};
            bitcnt <= bitcnt + 6'd1;
            oe     <= drive_bit(is_wr, bitcnt + 6'd1);
          end
        end
      end
      if (rise_tick && active && !is_wr && bitcnt >= 6'(DATA_FIRST))
        rdsh <= {rdsh[WORD_W-2:0], mdio_i};
    end
  end

  p_mdio_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_o != $past(mdio_o)) || (oe != $past(oe))) |-> $past(fall_tick));
  p_oe_starts_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (active && bitcnt == 6'd0));
  p_sample_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdsh != $past(rdsh)) |-> $past(rise_tick));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/mii_host_regs.sv
module mii_host_regs
  import mii_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              ack,
  input  logic              done,
  input  logic              done_rd,
  input  logic [WORD_W-1:0] eng_rdata,
  input  logic              eng_active,
  output logic              req_valid_o,
  output mgmt_req_t         req_o,
  output logic [2:0]        status_o,
  output logic [7:0]        rdata_lo_o,
  output logic [7:0]        rdata_hi_o
);
  logic [1:0]         cmd;
  logic [FIELD_W-1:0] sel, phy;
  logic [7:0]         wlo;
  logic [WORD_W-1:0]  wword, rdata;
  logic               pend_rd, pend_wr, nvalid, busy;
  logic               wr_cmd, launch_rd, launch_wr, scan_on;

  assign wr_cmd    = host_we && host_addr == HREG_CMD;
  assign launch_rd = wr_cmd && host_wdata[0] && !cmd[0];
  assign scan_on   = wr_cmd && host_wdata[1] && !cmd[1];
  assign launch_wr = host_we && host_addr == HREG_WHI;

  // Priority: write, then one-shot read, then scan.
  assign req_valid_o = pend_wr || pend_rd || cmd[1];
  assign req_o       = '{wr: pend_wr, phy: phy, regn: sel, wdata: wword};

  assign busy       = pend_rd || pend_wr || eng_active || done;
  assign status_o   = {nvalid, cmd[1], busy};
  assign rdata_lo_o = rdata[7:0];
  assign rdata_hi_o = rdata[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd     <= '0;
      sel     <= '0;
      phy     <= '0;
      wlo     <= '0;
      wword   <= '0;
      rdata   <= '0;
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
      nvalid  <= 1'b0;
    end else begin
      if (host_we) begin
        case (host_addr)
          HREG_CMD: cmd   <= host_wdata[1:0];
          HREG_SEL: sel   <= host_wdata[FIELD_W-1:0];
          HREG_WLO: wlo   <= host_wdata;
          HREG_WHI: wword <= {host_wdata, wlo};
          HREG_PHY: phy   <= host_wdata[FIELD_W-1:0];
          default: ;
        endcase
      end
      if (launch_wr)              pend_wr <= 1'b1;
      else if (ack && pend_wr)    pend_wr <= 1'b0;
      if (launch_rd)                         pend_rd <= 1'b1;
      else if (ack && !pend_wr && pend_rd)   pend_rd <= 1'b0;
      if (launch_rd || scan_on) nvalid <= 1'b1;
      else if (done_rd)         nvalid <= 1'b0;
      if (done_rd) rdata <= eng_rdata;
    end
  end

  p_launch_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_rd) |-> $past(wr_cmd && host_wdata[0] && !cmd[0]));
  p_busy_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  p_nvalid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nvalid) |-> $past(done_rd));
  p_write_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend_wr && !launch_wr) |=> (!pend_wr && $stable(pend_rd)));
endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mii_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [2:0] status_o,
  output logic [7:0] rdata_lo_o,
  output logic [7:0] rdata_hi_o,
  output logic       mdc_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic       mdio_i
);
  logic              rise_tick, fall_tick;
  logic              req_valid, ack, done, done_rd, active;
  mgmt_req_t         req;
  logic [WORD_W-1:0] eng_rdata;

  mii_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc_o(mdc_o),
    .rise_tick_o(rise_tick), .fall_tick_o(fall_tick)
  );

  mii_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .ack(ack), .done(done), .done_rd(done_rd),
    .eng_rdata(eng_rdata), .eng_active(active), .req_valid_o(req_valid),
    .req_o(req), .status_o(status_o), .rdata_lo_o(rdata_lo_o),
    .rdata_hi_o(rdata_hi_o)
  );

  mii_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .req_valid(req_valid), .req(req), .ack_o(ack), .done_o(done),
    .done_rd_o(done_rd), .rdata_o(eng_rdata), .active_o(active),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );
endmodule

// File: tb/mii_mgmt_engine_tb.sv
`timescale 1ns/1ps
module mii_mgmt_engine_tb;
  localparam int DIV = 4;
  localparam int FRAME_CYC = 64 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [2:0] status_o;
  logic [7:0] rdata_lo_o, rdata_hi_o;
  logic       mdc_o, mdio_o, mdio_oe_o;
  logic       mdio_i = 1'b1;

  always #4 clk = ~clk;

  mii_mgmt_engine #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .status_o(status_o), .rdata_lo_o(rdata_lo_o),
    .rdata_hi_o(rdata_hi_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int r);
    return 16'(32'hC35A ^ (r * 32'h0911));
  endfunction

  // Behavioural PHY
  logic [15:0] phy_mem [32];
  logic [15:0] shadow  [32];
  logic [33:0] hist = '0;
  int          pos = 0, frames = 0;
  logic [1:0]  f_op = '0, f_ta = '0;
  logic [4:0]  f_phy = '0, f_reg = '0;
  logic [15:0] f_data = '0;
  logic        f_ta_drv = 1'b0;
  logic [1:0]  l_op = '0, l_ta = '0;
  logic [4:0]  l_phy = '0, l_reg = '0;
  logic        l_ta_drv = 1'b0;
  logic [1:0]  op_log [64];

  always @(posedge mdc_o) begin
    if (pos == 0) begin
      if (mdio_oe_o) hist = {hist[32:0], mdio_o};
      else hist = '0;
      if (hist == {32'hFFFF_FFFF, 2'b01}) begin
        pos = 34; hist = '0; f_ta_drv = 1'b0;
      end
    end else begin
      if (pos < 36)      f_op  = {f_op[0], mdio_o};
      else if (pos < 41) f_phy = {f_phy[3:0], mdio_o};
      else if (pos < 46) f_reg = {f_reg[3:0], mdio_o};
      else if (pos < 48) begin
        f_ta = {f_ta[0], mdio_o};
        if (mdio_oe_o) f_ta_drv = 1'b1;
      end else f_data = {f_data[14:0], mdio_o};
      pos++;
      if (pos == 64) begin
        l_op = f_op; l_phy = f_phy; l_reg = f_reg; l_ta = f_ta; l_ta_drv = f_ta_drv;
        if (f_op == 2'b01) phy_mem[f_reg] = f_data;
        op_log[frames % 64] = f_op;
        frames++;
        pos = 0;
      end
    end
  end

  always @(negedge mdc_o) begin
    if (pos >= 48 && pos <= 63 && f_op == 2'b10) mdio_i = phy_mem[f_reg][63 - pos];
    else mdio_i = 1'b1;
  end

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (status_o[0] && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic do_read(input logic [4:0] r, input logic [4:0] p);
    host_wr(3'd4, {3'b0, p});
    host_wr(3'd0, 8'd0);
    host_wr(3'd1, {3'b0, r});
    host_wr(3'd0, 8'd1);
    check(status_o[0] == 1'b1, "R6", "busy after launch", status_o[0], 1);
    check(status_o[2] == 1'b1, "R7", "not-valid after launch", status_o[2], 1);
    wait_idle();
    check({rdata_hi_o, rdata_lo_o} == shadow[r], "R6", "read data",
          {rdata_hi_o, rdata_lo_o}, shadow[r]);
    check(status_o[2] == 1'b0, "R7", "not-valid cleared", status_o[2], 0);
    check(l_op == 2'b10 && l_reg == r, "R3", "read opcode/reg", {l_op, l_reg}, {2'b10, r});
    check(!l_ta_drv, "R3", "turnaround released", l_ta_drv, 0);
    check(l_phy == p, "R11", "phy address", l_phy, p);
  endtask

  task automatic do_write(input logic [4:0] r, input logic [4:0] p, input logic [15:0] d);
    host_wr(3'd4, {3'b0, p});
    host_wr(3'd1, {3'b0, r});
    host_wr(3'd2, d[7:0]);
    host_wr(3'd3, d[15:8]);
    check(status_o[0] == 1'b1, "R9", "busy after write launch", status_o[0], 1);
    wait_idle();
    shadow[r] = d;
    check(phy_mem[r] == d, "R9", "written data", phy_mem[r], d);
    check(l_op == 2'b01 && l_ta == 2'b10 && l_ta_drv, "R4", "write op/turnaround",
          {l_op, l_ta, l_ta_drv}, 5'b01101);
    check(l_phy == p, "R11", "phy address on write", l_phy, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int f0;
    realtime t0, t1, t2;
    void'($urandom(32'd2718));
    for (int r = 0; r < 32; r++) begin phy_mem[r] = init_val(r); shadow[r] = init_val(r); end
    repeat (5) @(negedge clk);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1", "mdc/oe in reset", {mdc_o, mdio_oe_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(status_o == 3'd0, "R1", "status after reset", status_o, 0);
    check({rdata_hi_o, rdata_lo_o} == 16'd0, "R1", "data after reset",
          {rdata_hi_o, rdata_lo_o}, 0);

    // R2: MDC shape
    @(posedge mdc_o); t0 = $realtime;
    @(negedge mdc_o); t1 = $realtime;
    @(posedge mdc_o); t2 = $realtime;
    check(int'((t2 - t0) / 8.0) == DIV, "R2", "mdc period", int'((t2 - t0) / 8.0), DIV);
    check(int'((t1 - t0) / 8.0) == DIV / 2, "R2", "mdc high time",
          int'((t1 - t0) / 8.0), DIV / 2);

    do_read(5'd3, 5'h0B);

    // R5: re-writing a still-set read bit does nothing
    f0 = frames;
    host_wr(3'd0, 8'd1);
    check(status_o[0] == 1'b0, "R5", "no busy on held bit", status_o[0], 0);
    repeat (3 * FRAME_CYC) @(negedge clk);
    check(frames == f0, "R5", "no extra frame", frames, f0);
    host_wr(3'd0, 8'd0);
    host_wr(3'd0, 8'd1);
    wait_idle();
    check(frames == f0 + 1, "R5", "relaunch after clear", frames, f0 + 1);

    do_write(5'd7, 5'h0B, 16'h1234);
    do_read(5'd7, 5'h0B);

    // R10: write and read queued behind a running read
    host_wr(3'd0, 8'd0);
    host_wr(3'd1, 8'd9);
    host_wr(3'd0, 8'd1);
    repeat (3 * DIV) @(negedge clk);
    f0 = frames;
    host_wr(3'd2, 8'h5A);
    host_wr(3'd3, 8'hC3);
    host_wr(3'd0, 8'd0);
    host_wr(3'd0, 8'd1);
    wait_idle();
    shadow[9] = 16'hC35A;
    check(frames == f0 + 3, "R10", "three frames", frames, f0 + 3);
    check(op_log[f0 % 64] == 2'b10 && op_log[(f0 + 1) % 64] == 2'b01 &&
          op_log[(f0 + 2) % 64] == 2'b10, "R10", "op order",
          {op_log[f0 % 64], op_log[(f0 + 1) % 64], op_log[(f0 + 2) % 64]}, 6'b100110);
    check({rdata_hi_o, rdata_lo_o} == 16'hC35A, "R10", "read after queued write",
          {rdata_hi_o, rdata_lo_o}, 16'hC35A);

    // R8: scan
    host_wr(3'd0, 8'd0);
    host_wr(3'd1, 8'd2);
    host_wr(3'd0, 8'd2);
    check(status_o[2:1] == 2'b11, "R8", "scan and not-valid set", status_o[2:1], 3);
    begin
      int k = 0;
      while (status_o[2] && k < 2000) begin @(negedge clk); k++; end
    end
    check({rdata_hi_o, rdata_lo_o} == shadow[2], "R8", "first scan data",
          {rdata_hi_o, rdata_lo_o}, shadow[2]);
    phy_mem[2] = 16'hBEEF; shadow[2] = 16'hBEEF;
    f0 = frames;
    begin
      int k = 0;
      while (frames < f0 + 2 && k < 3 * FRAME_CYC) begin @(negedge clk); k++; end
    end
    repeat (2 * DIV) @(negedge clk);
    check({rdata_hi_o, rdata_lo_o} == 16'hBEEF, "R8", "scan refresh",
          {rdata_hi_o, rdata_lo_o}, 16'hBEEF);
    check(status_o[1] == 1'b1, "R8", "scan bit held", status_o[1], 1);
    host_wr(3'd0, 8'd0);
    wait_idle();
    check(status_o == 3'd0, "R8", "status after scan off", status_o, 0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [4:0]  r, p;
      logic [15:0] d;
      r = 5'($urandom % 32);
      p = 5'($urandom % 32);
      d = 16'($urandom);
      if ($urandom % 2) do_write(r, p, d);
      else do_read(r, p);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule